// File: doc/BRIEF.md
# Battery-Backed Real-Time Clock Register Block

This block keeps wall-clock time behind a small 32-bit register bus. A 32-bit seconds counter is extended by a fractional counter that advances on a tick-enable input and wraps once per second, carrying into the seconds. A two-word alarm compare raises a sticky alarm flag when the time reaches it. A status word holds the handshake and event flags, and a single interrupt output combines the flags that software has enabled.

Register writes are posted. An accepted write sets a busy flag and waits a fixed number of slow-clock enables before it takes effect. It then raises write-complete. A write issued while busy is dropped and raises write-error. Software must therefore wait for complete or error before it issues the next write. Timekeeping is held off until three things are true: the non-valid flag, which is set at reset, has been acknowledged; the seconds register has been written at least once; and the enable bit is set.

Top module: `rtc_regblock`

## Requirements
- R1: After reset the status reads 0x0000_0202 (bit 9 ready, bit 1 non-valid), the seconds and fraction read 0, the alarm seconds reads 0xFFFF_FFFF, the alarm fraction reads 0, and irq is low.
- R2: Byte offsets, decoded from addr[4:2]: 0x00 seconds, 0x04 fraction, 0x08 alarm seconds, 0x0C alarm fraction, 0x10 control (bit 3 = count enable), 0x14 status, 0x18 interrupt enable (bits 9, 8, 7, 4). Each register reads back what was last committed to it.
- R3: A write accepted while idle sets status bit 10 (busy) and clears bit 9 (ready) and bit 8 (complete) on the next cycle. The target register keeps its old value until WR_SLOW_CYCLES slow enables have passed. At that point the value is applied, bit 10 clears, and bits 9 and 8 set.
- R4: A write issued while busy changes no register and sets status bit 7 (write error).
- R5: Status bits 7 (write error) and 4 (alarm) clear when a completed status write carries a 1 in their position. Writing to bits 10, 9 and 8 has no effect.
- R6: The non-valid flag (status bit 1) clears only when a status write has both bits 1 and 0 set. A write with bit 1 alone leaves it set.
- R7: Both counters hold still unless three conditions all hold: control bit 3 is set, the seconds register has been written since reset, and non-valid is clear.
- R8: While counting, each tick adds one to the fraction. After TICKS_PER_SEC ticks the fraction returns to 0 and the seconds count increments.
- R9: While counting, status bit 4 sets when seconds and fraction both equal the alarm registers. An alarm seconds value of 0xFFFF_FFFF disables the match.
- R10: irq is the OR of each of ready (bit 9), complete (bit 8), error (bit 7) and alarm (bit 4), each ANDed with the interrupt-enable bit in the same position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_en | input | 1 | Slow-clock enable that paces write completion |
| tick_en | input | 1 | Fraction counter advance enable |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 3 | Word select, byte address bits 4 to 2 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| irq | output | 1 | Combined enabled-flag interrupt |

## Verification
If the busy counter or the pending-write store goes wrong, a register reads back its new value too early, or a wrong value shows up at completion. If the busy state sticks, every later write fails. Both problems appear within one write's latency of WR_SLOW_CYCLES slow enables. A wrong run condition shows up within one tick, because the fraction moves while it should be frozen or stays put while it should move. A fault in the carry or the alarm compare shows up at the first wrap or the first matching tick, either as a wrong seconds value or as the alarm flag and irq changing at the wrong time.

// File: rtl/rtc_regblock.sv
module rtc_regblock #(
  parameter int unsigned TICKS_PER_SEC  = 32768,
  parameter int unsigned WR_SLOW_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_en,
  input  logic        tick_en,
  input  logic        wr_en,
  input  logic [4:2]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam int          CW        = $clog2(WR_SLOW_CYCLES + 1);
  localparam logic [CW-1:0] LAST    = CW'(WR_SLOW_CYCLES - 1);
  localparam logic [31:0] FRAC_LAST = 32'(TICKS_PER_SEC - 1);
  localparam logic [2:0]  A_SEC = 3'd0, A_FRAC = 3'd1, A_ASEC = 3'd2, A_AFRAC = 3'd3,
                          A_CTRL = 3'd4, A_STAT = 3'd5, A_IER = 3'd6;

  logic [31:0] sec_q, frac_q, alm_sec_q, alm_frac_q, p_data;
  logic [2:0]  p_idx;
  logic [CW-1:0] cnt_q;
  logic [3:0]  ier_q;
  logic tce_q, busy_q, wnf_q, wcf_q, wef_q, caf_q, nvf_q, sec_init_q;

  logic accept, reject, commit, run, wrap, step, alarm_hit;
  logic [31:0] st_clr, status;

  assign accept    = wr_en & ~busy_q;
  assign reject    = wr_en & busy_q;
  assign commit    = busy_q & slow_en & (cnt_q == LAST);
  assign run       = tce_q & sec_init_q & ~nvf_q;
  assign wrap      = (frac_q == FRAC_LAST);
  assign step      = run & tick_en;
  assign alarm_hit = run & (alm_sec_q != 32'hFFFF_FFFF) &
                     (sec_q == alm_sec_q) & (frac_q == alm_frac_q);
  assign st_clr    = (commit && p_idx == A_STAT) ? p_data : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; wnf_q <= 1'b1; wcf_q <= 1'b0;
      cnt_q <= '0; p_idx <= '0; p_data <= '0;
    end else if (accept) begin
      busy_q <= 1'b1; wnf_q <= 1'b0; wcf_q <= 1'b0;
      cnt_q <= '0; p_idx <= addr; p_data <= wdata;
    end else if (busy_q && slow_en) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0; wnf_q <= 1'b1; wcf_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0; frac_q <= '0; sec_init_q <= 1'b0;
      alm_sec_q <= 32'hFFFF_FFFF; alm_frac_q <= '0;
      tce_q <= 1'b0; ier_q <= '0;
    end else begin
      if (commit && p_idx == A_SEC) begin
        sec_q <= p_data; sec_init_q <= 1'b1;
      end else if (step && wrap) begin
        sec_q <= sec_q + 1'b1;
      end
      if (commit && p_idx == A_FRAC) frac_q <= p_data;
      else if (step)                 frac_q <= wrap ? 32'd0 : frac_q + 1'b1;
      if (commit && p_idx == A_ASEC)  alm_sec_q  <= p_data;
      if (commit && p_idx == A_AFRAC) alm_frac_q <= p_data;
      if (commit && p_idx == A_CTRL)  tce_q <= p_data[3];
      if (commit && p_idx == A_IER)   ier_q <= {p_data[9], p_data[8], p_data[7], p_data[4]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wef_q <= 1'b0; caf_q <= 1'b0; nvf_q <= 1'b1;
    end else begin
      wef_q <= reject    | (wef_q & ~st_clr[7]);
      caf_q <= alarm_hit | (caf_q & ~st_clr[4]);
      nvf_q <= nvf_q & ~(st_clr[1] & st_clr[0]);
    end
  end

  assign status = {21'd0, busy_q, wnf_q, wcf_q, wef_q, 2'b00, caf_q, 2'b00, nvf_q, 1'b0};

  always_comb begin
    case (addr)
      A_SEC:   rdata = sec_q;
      A_FRAC:  rdata = frac_q;
      A_ASEC:  rdata = alm_sec_q;
      A_AFRAC: rdata = alm_frac_q;
      A_CTRL:  rdata = {28'd0, tce_q, 3'b000};
      A_STAT:  rdata = status;
      A_IER:   rdata = {22'd0, ier_q[3], ier_q[2], ier_q[1], 2'b00, ier_q[0], 4'd0};
      default: rdata = 32'd0;
    endcase
  end

  assign irq = (ier_q[3] & wnf_q) | (ier_q[2] & wcf_q) | (ier_q[1] & wef_q) | (ier_q[0] & caf_q);
endmodule

// File: rtl/rtc_regblock_chk.sv
module rtc_regblock_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        busy,
  input logic        wcf,
  input logic        wef,
  input logic        nvf,
  input logic        run,
  input logic        commit,
  input logic [2:0]  p_idx,
  input logic [31:0] sec,
  input logic [31:0] frac
);
  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy) |=> busy);
  // R3
  complete_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wcf) |-> $past(busy));
  // R4
  reject_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> wef);
  // R6
  nvf_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nvf) |-> $past(commit && p_idx == 3'd5));
  // R7
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !commit) |=> ($stable(sec) && $stable(frac)));
endmodule

bind rtc_regblock rtc_regblock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy_q), .wcf(wcf_q),
  .wef(wef_q), .nvf(nvf_q), .run(run), .commit(commit), .p_idx(p_idx),
  .sec(sec_q), .frac(frac_q)
);

// File: tb/rtc_regblock_bench.sv
module rtc_regblock_bench;
  localparam int TPS = 8;
  localparam logic [4:0] O_SEC = 5'h00, O_FRAC = 5'h04, O_ASEC = 5'h08, O_AFRAC = 5'h0C,
                         O_CTRL = 5'h10, O_STAT = 5'h14, O_IER = 5'h18;

  logic clk = 0, rst_n = 0, slow_en = 0, tick_en = 0, wr_en = 0;
  logic [4:2] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, errors = 0, phase = 0;
  bit done = 0;

  rtc_regblock #(.TICKS_PER_SEC(TPS), .WR_SLOW_CYCLES(4)) u_rtc_regblock (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #5 clk = ~clk;

  initial forever begin
    @(negedge clk);
    phase = (phase + 1) % 3;
    slow_en = (phase == 0);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] off, output logic [31:0] d);
    @(negedge clk); addr = off[4:2]; #1 d = rdata;
  endtask

  task automatic wr(input logic [4:0] off, input logic [31:0] d);
    @(negedge clk); addr = off[4:2]; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin
      rd(O_STAT, s);
      if (!s[10] && (s[8] || s[7])) return;
    end
    check("R3 wait", 32'd0, 32'd1);
  endtask

  task automatic wrw(input logic [4:0] off, input logic [31:0] d);
    wr(off, d); wait_done();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1; @(negedge clk); tick_en = 0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(O_STAT, d);  check("R1 status", d, 32'h202);
    rd(O_SEC, d);   check("R1 seconds", d, 0);
    rd(O_ASEC, d);  check("R1 alarm sec", d, 32'hFFFF_FFFF);
    rd(O_AFRAC, d); check("R1 alarm frac", d, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_handshake();
    logic [31:0] d;
    wr(O_AFRAC, 5);
    rd(O_AFRAC, d); check("R3 posted value", d, 0);
    rd(O_STAT, d);  check("R3 busy status", d, 32'h402);
    wr(O_AFRAC, 9);
    rd(O_STAT, d);  check("R4 error while busy", d, 32'h482);
    wait_done();
    rd(O_AFRAC, d); check("R4 rejected not applied", d, 5);
    rd(O_STAT, d);  check("R3 complete status", d, 32'h382);
    wrw(O_STAT, 32'h80);
    rd(O_STAT, d);  check("R5 error cleared", d, 32'h302);
    wrw(O_STAT, 32'h700);
    rd(O_STAT, d);  check("R5 hw bits unaffected", d, 32'h302);
    wrw(O_CTRL, 32'h8);
    rd(O_CTRL, d);  check("R2 control readback", d, 32'h8);
    wrw(O_IER, 32'hFFFF_FFFF);
    rd(O_IER, d);   check("R2 ier readback", d, 32'h390);
    wrw(O_IER, 0);
  endtask

  task automatic t_valid_and_start();
    logic [31:0] d;
    ticks(3);
    rd(O_FRAC, d); check("R7 frozen while non-valid", d, 0);
    wrw(O_STAT, 32'h2);
    rd(O_STAT, d); check("R6 bit1 alone keeps non-valid", d, 32'h302);
    wrw(O_STAT, 32'h3);
    rd(O_STAT, d); check("R6 both bits clear non-valid", d, 32'h300);
    ticks(3);
    rd(O_FRAC, d); check("R7 frozen until seconds written", d, 0);
    wrw(O_SEC, 100);
    ticks(TPS);
    rd(O_SEC, d);  check("R8 carry into seconds", d, 101);
    rd(O_FRAC, d); check("R8 fraction wrapped", d, 0);
    ticks(3);
    rd(O_FRAC, d); check("R8 fraction steps", d, 3);
  endtask

  task automatic t_alarm();
    logic [31:0] d;
    wrw(O_AFRAC, 6);
    wrw(O_ASEC, 101);
    wrw(O_IER, 32'h10);
    ticks(2);
    rd(O_STAT, d); check("R9 no alarm before match", d[4], 0);
    check("R10 irq low before match", irq, 0);
    ticks(1);
    rd(O_STAT, d); check("R9 alarm on match", d[4], 1);
    check("R10 irq from alarm", irq, 1);
    ticks(1);
    wrw(O_STAT, 32'h10);
    rd(O_STAT, d); check("R5 alarm cleared", d[4], 0);
    check("R10 irq follows clear", irq, 0);
    wrw(O_ASEC, 32'hFFFF_FFFF);
    wrw(O_AFRAC, 0);
    wrw(O_FRAC, 0);
    wrw(O_SEC, 32'hFFFF_FFFF);
    repeat (4) @(negedge clk);
    rd(O_STAT, d); check("R9 all-ones alarm disabled", d[4], 0);
  endtask

  task automatic t_irq_and_stop();
    logic [31:0] d, f;
    wrw(O_IER, 32'h200);
    check("R10 irq from ready", irq, 1);
    wrw(O_IER, 32'h100);
    check("R10 irq from complete", irq, 1);
    wrw(O_IER, 32'h80);
    check("R10 irq error masked when clear", irq, 0);
    wrw(O_CTRL, 0);
    rd(O_FRAC, f);
    ticks(5);
    rd(O_FRAC, d); check("R7 frozen when disabled", d, f);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_handshake();
    t_valid_and_start();
    t_alarm();
    t_irq_and_stop();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule